// File: doc/BRIEF.md
# DRAM Refresh Slot Scheduler

This block turns a fast master oscillator into CPU cycle slots. It also decides, slot by slot, whether a slot serves the processor or is given to a DRAM refresh cycle. A slot counter divides the master clock into slots of five master clocks each. From a 14.31818 MHz oscillator this gives CPU slots at roughly 2.86 MHz. At every slot boundary a scheduler samples the mode select, the processor's "internal operation" flag and its memory request. These three inputs describe the slot that is about to begin, and the scheduler uses them to plan that slot.

Refresh always uses CAS-before-RAS signalling, so the DRAM's own row counter supplies the row and no refresh address leaves the block. The block has two modes:

- **Steal mode** takes every tenth slot for refresh, so the processor keeps at most nine slots in ten.
- **Hidden mode** looks for a slot that the processor spends on internal work and places the refresh there. It forces a refresh only when no such slot has come by the tenth slot.

In either mode the processor is stalled only when a refresh slot coincides with a real memory request.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: A slot lasts exactly SLOT_CLKS (5) master clocks. `cpu_ce` is high for exactly one master clock, the last one of each slot, and stays low for the whole of a stalled slot.
- R2: In steal mode (`mode_hidden`=0) a refresh occupies exactly every REF_INTERVAL-th (10th) slot. Slot 0 is the slot that starts at reset, and the first refresh falls in slot 10. The `cpu_internal` flag does not move a refresh in this mode.
- R3: In a refresh slot, with the slot's master clocks numbered 0 to 4, `cas_n` is low in clocks 1 to 3 and `ras_n` is low in clocks 2 to 3. CAS therefore falls one clock before RAS, and RAS stays low for two clocks. Both strobes are high in clocks 0 and 4 and during every non-refresh slot.
- R4: In hidden mode (`mode_hidden`=1) a refresh is placed in a slot flagged by `cpu_internal` once at least HIDE_MIN (5) non-refresh slots have passed since the last refresh. An internal slot that comes earlier gets no refresh.
- R5: In hidden mode, when no suitable internal slot has arrived, a refresh is forced into the 10th slot after the previous one, as in steal mode.
- R6: `cpu_stall` is high for the whole refresh slot if, and only if, `cpu_mem_req`=1 and `cpu_internal`=0 at the boundary that starts that slot. It is never high outside a refresh slot and never high in a slot flagged as internal.
- R7: While `rst` is high, `ras_n` and `cas_n` are high, `ref_busy`, `cpu_stall` and `cpu_ce` are low, and the slot and refresh counters restart, so that the first refresh starts within ten slots of reset.
- R8: The mode select and the CPU flags are used only at slot boundaries. A change in the middle of a slot does not alter that slot's strobes, stall or refresh flag.
- R9: `ref_busy` is high for all SLOT_CLKS clocks of every refresh slot and low otherwise.
- R10: In either mode, and across any mix of mode changes, no more than REF_INTERVAL slots separate the starts of two consecutive refresh slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_hidden | input | 1 | 0 = steal every tenth slot, 1 = hide refresh in internal slots |
| cpu_internal | input | 1 | The coming slot is an internal, non-memory CPU operation |
| cpu_mem_req | input | 1 | The CPU wants a memory access in the coming slot |
| cpu_ce | output | 1 | One-clock CPU clock enable at the end of each slot that is not stalled |
| cpu_stall | output | 1 | CPU held off for the whole current slot |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| ref_busy | output | 1 | The current slot is a refresh slot |

## Verification
The bench builds the block with its default parameters: five-clock slots, a ten-slot refresh interval and a hidden-mode threshold of five. These values put the full refresh interval within a few dozen master clocks, so forced refreshes, early internal slots that must be ignored, and refreshes hidden in internal slots all occur many times in a short run. With five clocks per slot, every position of the strobe window can be sampled on its own, which makes the CAS-then-RAS order and the idle clocks at both ends of the slot directly observable. Mode flips in the middle of a slot and a second reset in the middle of a run show that decisions are taken only at boundaries and that the counters restart.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic {
        MODE_STEAL  = 1'b0,
        MODE_HIDDEN = 1'b1
    } ref_mode_e;

    // Plan for one CPU slot, fixed at the boundary that opens it.
    typedef struct packed {
        logic refresh;
        logic stall;
    } slot_plan_t;

    // True when phase p lies inside the inclusive window [lo, hi].
    function automatic logic in_window(input int p, input int lo, input int hi);
        return (p >= lo) && (p <= hi);
    endfunction

    // Decide whether the coming slot is a refresh slot.
    function automatic logic want_refresh(input ref_mode_e mode,
                                          input logic      internal_op,
                                          input int        since_ref,
                                          input int        interval,
                                          input int        hide_min);
        logic forced;
        logic hidden;
        forced = (since_ref >= interval - 1);
        hidden = (mode == MODE_HIDDEN) && internal_op && (since_ref >= hide_min);
        return forced || hidden;
    endfunction

endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
    parameter int SLOT_CLKS = 5,
    localparam int PW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase_q,
    output logic [PW-1:0] phase_next,
    output logic          boundary
);
    localparam logic [PW-1:0] LAST = PW'(SLOT_CLKS - 1);

    assign boundary   = (phase_q == LAST);
    assign phase_next = boundary ? '0 : phase_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_next;
    end

    // R1: a slot wraps after its last clock
    a_r1_slot_wrap: assert property (@(posedge clk) disable iff (rst)
        (phase_q == LAST) |=> (phase_q == '0));

    // R1: the phase never leaves the slot range
    a_r1_phase_range: assert property (@(posedge clk) disable iff (rst)
        phase_q <= LAST);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_pkg::*;
#(
    parameter int REF_INTERVAL = 10,
    parameter int HIDE_MIN     = 5,
    localparam int CW = $clog2(REF_INTERVAL + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       boundary,
    input  ref_mode_e  mode,
    input  logic       cpu_internal,
    input  logic       cpu_mem_req,
    output slot_plan_t plan_q
);
    logic [CW-1:0] since_q;
    slot_plan_t    plan_d;

    always_comb begin
        plan_d.refresh = want_refresh(mode, cpu_internal, int'(since_q),
                                      REF_INTERVAL, HIDE_MIN);
        plan_d.stall   = plan_d.refresh && cpu_mem_req && !cpu_internal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            plan_q  <= '0;
        end else if (boundary) begin
            plan_q  <= plan_d;
            since_q <= plan_d.refresh ? '0 : since_q + 1'b1;
        end
    end

    // R10: the count of slots without refresh stays below the interval
    a_r10_gap_bound: assert property (@(posedge clk) disable iff (rst)
        int'(since_q) < REF_INTERVAL);

    // R8: the plan only changes at slot boundaries
    a_r8_plan_held: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(plan_q));

    // R6: an internal slot is never stalled
    a_r6_internal_free: assert property (@(posedge clk) disable iff (rst)
        (boundary && cpu_internal) |=> !plan_q.stall);

    // R6: a stall only accompanies a refresh slot
    a_r6_stall_in_ref: assert property (@(posedge clk) disable iff (rst)
        plan_q.stall |-> plan_q.refresh);

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
    import refresh_pkg::*;
#(
    parameter int SLOT_CLKS = 5,
    parameter int CAS_LEAD  = 1,
    parameter int RAS_CLKS  = 2,
    localparam int PW     = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1,
    localparam int CAS_LO = 1,
    localparam int RAS_LO = CAS_LO + CAS_LEAD,
    localparam int RAS_HI = RAS_LO + RAS_CLKS - 1,
    localparam int CAS_HI = RAS_HI
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] phase_next,
    input  logic          refresh,
    output logic          ras_n,
    output logic          cas_n
);
    // Strobes are registered: they follow the phase the slot enters next.
    // The plan changes only when phase_next is 0, which lies outside both windows.
    always_ff @(posedge clk) begin
        if (rst) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
        end else begin
            cas_n <= !(refresh && in_window(int'(phase_next), CAS_LO, CAS_HI));
            ras_n <= !(refresh && in_window(int'(phase_next), RAS_LO, RAS_HI));
        end
    end

    // R3: RAS falls only after CAS is already low
    a_r3_cas_first: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> !$past(cas_n));

    // R3: RAS is never low without CAS
    a_r3_ras_inside_cas: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> !cas_n);

    // R3: both strobes are idle outside refresh slots
    a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
        !refresh |-> (ras_n && cas_n));

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import refresh_pkg::*;
#(
    parameter int SLOT_CLKS    = 5,
    parameter int REF_INTERVAL = 10,
    parameter int HIDE_MIN     = 5,
    parameter int CAS_LEAD     = 1,
    parameter int RAS_CLKS     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_hidden,
    input  logic cpu_internal,
    input  logic cpu_mem_req,
    output logic cpu_ce,
    output logic cpu_stall,
    output logic ras_n,
    output logic cas_n,
    output logic ref_busy
);
    localparam int PW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] phase_next;
    logic          boundary;
    slot_plan_t    plan;
    ref_mode_e     mode;

    assign mode = mode_hidden ? MODE_HIDDEN : MODE_STEAL;

    slot_timer #(.SLOT_CLKS(SLOT_CLKS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .phase_q    (phase_q),
        .phase_next (phase_next),
        .boundary   (boundary)
    );

    refresh_sched #(.REF_INTERVAL(REF_INTERVAL), .HIDE_MIN(HIDE_MIN)) u_sched (
        .clk          (clk),
        .rst          (rst),
        .boundary     (boundary),
        .mode         (mode),
        .cpu_internal (cpu_internal),
        .cpu_mem_req  (cpu_mem_req),
        .plan_q       (plan)
    );

    strobe_gen #(.SLOT_CLKS(SLOT_CLKS), .CAS_LEAD(CAS_LEAD), .RAS_CLKS(RAS_CLKS)) u_strobe (
        .clk        (clk),
        .rst        (rst),
        .phase_next (phase_next),
        .refresh    (plan.refresh),
        .ras_n      (ras_n),
        .cas_n      (cas_n)
    );

    assign cpu_ce    = boundary && !plan.stall && !rst;
    assign cpu_stall = plan.stall;
    assign ref_busy  = plan.refresh;

    // R7: reset leaves the strobes idle on the next clock
    a_r7_reset_idle: assert property (@(posedge clk)
        rst |=> (ras_n && cas_n && !ref_busy && !cpu_stall));

    // R1: a stalled slot gives the CPU no clock enable
    a_r1_no_ce_when_stalled: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |-> !cpu_ce);

endmodule

// File: tb/test_dram_refresh_ctrl.sv
module test_dram_refresh_ctrl;
    localparam int SLOT  = 5;
    localparam int IVL   = 10;
    localparam int HMIN  = 5;
    localparam int NVEC  = 32;

    // Vector bits: {mode_hidden, cpu_internal, cpu_mem_req, flip_mode_mid_slot}
    localparam logic [3:0] VEC [NVEC] = '{
        4'b0010, 4'b0010, 4'b0110, 4'b0010, 4'b0000, 4'b0110, 4'b0010, 4'b0010,
        4'b0010, 4'b0010, 4'b0010, 4'b0011, 4'b0100, 4'b0010, 4'b0110, 4'b0110,
        4'b0000, 4'b0010, 4'b0010, 4'b0010, 4'b0111, 4'b1110, 4'b1010, 4'b1010,
        4'b1110, 4'b1010, 4'b1010, 4'b1110, 4'b1010, 4'b1011, 4'b1110, 4'b1010
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_hidden = 1'b0, cpu_internal = 1'b0, cpu_mem_req = 1'b0;
    logic cpu_ce, cpu_stall, ras_n, cas_n, ref_busy;

    int checks = 0, errors = 0;
    int cnt_m = 0, slot_idx = 0, last_ref = 0, stalls_seen = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dram_refresh_ctrl #(.SLOT_CLKS(SLOT), .REF_INTERVAL(IVL), .HIDE_MIN(HMIN)) i_dram_refresh_ctrl (
        .clk(clk), .rst(rst), .mode_hidden(mode_hidden), .cpu_internal(cpu_internal),
        .cpu_mem_req(cpu_mem_req), .cpu_ce(cpu_ce), .cpu_stall(cpu_stall),
        .ras_n(ras_n), .cas_n(cas_n), .ref_busy(ref_busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s slot %0d: actual %0d expected %0d", tag, slot_idx, act, exp);
        end
    endtask

    // Reset and align to the negedge just before the first slot boundary.
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R7: reset state at the ports
        chk("R7 ras_n", int'(ras_n), 1);
        chk("R7 cas_n", int'(cas_n), 1);
        chk("R7 ref_busy", int'(ref_busy), 0);
        chk("R7 cpu_stall", int'(cpu_stall), 0);
        chk("R7 cpu_ce", int'(cpu_ce), 0);
        rst = 1'b0;
        cnt_m = 0; slot_idx = 0; last_ref = 0;
        repeat (SLOT - 1) @(negedge clk);
    endtask

    // Drive one slot and check it clock by clock.
    task automatic run_slot(input logic md, input logic intl, input logic req, input logic flip);
        logic exp_ref, exp_stall;
        mode_hidden = md; cpu_internal = intl; cpu_mem_req = req;
        exp_ref = (cnt_m >= IVL - 1) || (md && intl && cnt_m >= HMIN);
        exp_stall = exp_ref && req && !intl;
        @(posedge clk);
        slot_idx++;
        for (int p = 0; p < SLOT; p++) begin
            @(negedge clk);
            if (p == 1 && flip) begin
                mode_hidden = ~mode_hidden; cpu_internal = ~cpu_internal; cpu_mem_req = ~cpu_mem_req;
            end
            // R3: strobe windows inside the slot
            chk("R3 cas_n", int'(cas_n), int'(!(exp_ref && p >= 1 && p <= 3)));
            chk("R3 ras_n", int'(ras_n), int'(!(exp_ref && p >= 2 && p <= 3)));
            // R9 / R8: refresh flag held for the whole slot
            chk(flip ? "R8 ref_busy" : "R9 ref_busy", int'(ref_busy), int'(exp_ref));
            // R6: stall for the whole slot
            chk(flip ? "R8 cpu_stall" : "R6 cpu_stall", int'(cpu_stall), int'(exp_stall));
            // R1: clock enable only on the last clock of an unstalled slot
            chk("R1 cpu_ce", int'(cpu_ce), int'(p == SLOT - 1 && !exp_stall));
        end
        if (cpu_stall) stalls_seen++;
        // R10 / R2 / R5: spacing between refresh slots
        if (exp_ref) begin
            chk("R10 gap", slot_idx - last_ref <= IVL ? 1 : 0, 1);
            last_ref = slot_idx;
        end else begin
            chk("R10 no overdue slot", slot_idx - last_ref < IVL ? 1 : 0, 1);
        end
        cnt_m = exp_ref ? 0 : cnt_m + 1;
    endtask

    initial begin
        do_reset();
        // Table walk: steal mode (R2) then hidden mode (R4, R5), with mid-slot flips (R8)
        for (int i = 0; i < NVEC; i++)
            run_slot(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);

        // R2: steal mode with internal slots everywhere still refreshes only every tenth slot
        do_reset();
        for (int i = 0; i < 25; i++) begin
            run_slot(1'b0, 1'b1, 1'b0, 1'b0);
            if (slot_idx == 10 || slot_idx == 20) chk("R2 tenth slot", int'(last_ref), slot_idx);
        end

        // R5: hidden mode without internal slots forces refresh at the tenth slot
        do_reset();
        for (int i = 0; i < 21; i++) run_slot(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R5 forced refresh", last_ref, 20);

        // R4: frequent internal slots in hidden mode leave no stall
        do_reset();
        stalls_seen = 0;
        for (int i = 0; i < 40; i++) run_slot(1'b1, i[0], !i[0], 1'b0);
        chk("R4 no stall when hidden", stalls_seen, 0);

        // R4: internal slot before the threshold gets no refresh
        do_reset();
        run_slot(1'b1, 1'b0, 1'b1, 1'b0);
        run_slot(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R4 early internal ignored", last_ref, 0);

        // R7: reset in the middle of a run restarts the schedule
        for (int i = 0; i < 4; i++) run_slot(1'b0, 1'b0, 1'b1, 1'b0);
        do_reset();
        for (int i = 0; i < 10; i++) run_slot(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R7 first refresh after reset", last_ref, 10);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule